// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes frames that arrive one byte per cycle on a valid/last stream, with an error sideband that is valid alongside the final byte. It stores each frame in host memory using a circular list of descriptors. Each descriptor is four 32-bit words: a status word, a size word, a buffer pointer and a link to the next descriptor. The writer reads a descriptor and checks that the host has handed it over. It then copies the frame bytes into the buffer, writes a completed status word back, and follows the link to the next descriptor.

When the writer reaches a descriptor that the host still holds, it raises a no-buffer flag. It then keeps accepting and throwing away input, so the upstream receiver never stalls. It stays in this state until the host issues a poll demand. A frame that is being dropped when the poll arrives is still dropped in full. The writer reads the descriptor again only at the next frame boundary.

Memory is reached through a simple request/acknowledge port. Frame bytes are written one byte at a time, using a single byte strobe on a 32-bit data bus. Descriptor words are read and written as whole words.

Top module: `rxr_ring_writer`

## Requirements
- R1: Frame byte i is written to buffer address + i, in arrival order, with exactly one byte strobe set.
- R2: The status write-back clears bit 31 (the ownership flag). It sets bit 9 (first piece of frame) and bit 8 (last piece of frame), and leaves bit 10 and bits 15:11 at zero.
- R3: Status bits 26:16 hold the number of bytes stored, counting the trailing 4-byte CRC that is present in the input stream.
- R4: The error sideband sampled with the last byte is copied to status bits 7:0. In bit order 0 to 7 these are: receive error, CRC error, alignment error, FIFO overflow, long packet, runt, system error and buffer underflow.
- R5: Bytes beyond the buffer capacity (size word bits 10:0) are not written. The long-packet flag (bit 4) is set and the length field equals the capacity.
- R6: After a write-back, the writer moves to the descriptor named by the link word at offset 12. A ring that loops back reuses its first descriptor.
- R7: `rx_ok` pulses for one cycle for each frame that is stored, and never for a dropped frame.
- R8: A fetched status word with bit 31 clear sets `nobuf`. While `nobuf` is set, `rx_ready` is high, input is discarded and no memory write is issued.
- R9: A poll demand while `nobuf` is set makes the writer fetch the same descriptor again and clears `nobuf`. If the host has returned that descriptor, the next frame is stored in it.
- R10: If the poll demand arrives in the middle of a discarded frame, the rest of that frame is still discarded, and no part of it reaches memory.
- R11: During reset `rx_ready`, `rx_ok` and `nobuf` are low, and the first descriptor read after reset is taken from `ring_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | ADDR_W | Address of the first descriptor |
| rx_valid | input | 1 | Input byte valid |
| rx_data | input | 8 | Input byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_err | input | 8 | Error causes, valid with the final byte |
| rx_ready | output | 1 | Byte accepted when high together with rx_valid |
| poll_demand | input | 1 | Host request to retry the descriptor fetch |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte strobes |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| rx_ok | output | 1 | One-cycle pulse: frame stored |
| nobuf | output | 1 | No host-owned descriptor available |

## Verification
The storage path is tested with three kinds of frame. A clean frame that fits its buffer checks the byte order and the basic status. A frame longer than its buffer shows that truncation stops the writes and reports the stored length rather than the received one. A frame that carries several error bits shows that each cause lands in its own status bit. A three-descriptor ring is then run until it wraps onto a descriptor the host has not returned. This separates a dropped frame from a stored one, both at the buffer and in the `rx_ok` count. Finally, the host returns the descriptor and issues a poll in the middle of a frame. This tells a clean frame-boundary restart apart from one that would write the tail of the dropped frame into memory.

// File: rtl/rxr_pkg.sv
// Package: shared state type and descriptor field positions for the
// receive ring writer. Assumes 32-bit descriptor words.
package rxr_pkg;
    localparam int OWN_BIT  = 31;
    localparam int LEN_LSB  = 16;
    localparam int LEN_W    = 11;
    localparam int LONG_BIT = 4;
    localparam int ERR_W    = 8;

    typedef enum logic [2:0] {
        S_FSTAT,
        S_FSIZE,
        S_FADDR,
        S_FNEXT,
        S_NOBUF,
        S_RXIDLE,
        S_WBYTE,
        S_WSTAT
    } wr_state_t;
endpackage

// File: rtl/rxr_status_pack.sv
// Builds the status word written back on completion. The ownership flag is
// left clear and the frame is marked as a single-piece chain (start and end).
// Assumes len already reflects truncation.
module rxr_status_pack
    import rxr_pkg::*;
(
    input  logic [LEN_W-1:0] len,
    input  logic [ERR_W-1:0] err,
    input  logic             trunc,
    output logic [31:0]      word
);
    // Assemble the fields into their bit positions
    always_comb begin
        word = '0;
        word[LEN_LSB +: LEN_W] = len;
        word[9]                = 1'b1;
        word[8]                = 1'b1;
        word[ERR_W-1:0]        = err;
        word[LONG_BIT]         = err[LONG_BIT] | trunc;
    end
endmodule

// File: rtl/rxr_drop_ctl.sv
// Tracks frame boundaries while input is discarded and decides when the
// writer may retry the fetch: a poll has been seen and no frame is open.
// Assumes rx_ready is high whenever active is high.
module rxr_drop_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rx_valid,
    input  logic rx_last,
    input  logic poll,
    output logic release_o
);
    logic mid_q;
    logic pend_q;

    // Remember whether a discarded frame is still open
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            mid_q <= 1'b0;
        else if (rx_valid)
            mid_q <= !rx_last;
    end

    // Hold a poll demand seen during the discard period
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            pend_q <= 1'b0;
        else if (poll)
            pend_q <= 1'b1;
    end

    // Leave only between frames
    assign release_o = active && (pend_q || poll) && !mid_q && !rx_valid;
endmodule

// File: rtl/rxr_ring_writer.sv
// Receive descriptor ring writer. It fetches a four-word descriptor
// (status, size, buffer, link), stores frame bytes one at a time, writes the
// status back and follows the link. If it meets a descriptor the host still
// holds, it discards input until a poll demand arrives. Assumes mem_ack
// pulses once per request and mem_rdata is valid with it.
module rxr_ring_writer
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic [ERR_W-1:0]  rx_err,
    output logic              rx_ready,
    input  logic              poll_demand,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_wstrb,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              rx_ok,
    output logic              nobuf
);
    localparam logic [ADDR_W-1:0] OFS_SIZE = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_BUF  = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] OFS_LINK = ADDR_W'(12);

    wr_state_t         state_q;
    logic [ADDR_W-1:0] desc_q, next_q, buf_q;
    logic [LEN_W-1:0]  cap_q, cnt_q;
    logic [7:0]        byte_q;
    logic              last_q, trunc_q, ok_q, nobuf_q;
    logic [ERR_W-1:0]  err_q;
    logic [31:0]       stat_word;
    logic              drop_release;
    logic [ADDR_W-1:0] byte_addr;

    rxr_status_pack u_pack (
        .len   (cnt_q),
        .err   (err_q),
        .trunc (trunc_q),
        .word  (stat_word)
    );

    rxr_drop_ctl u_drop (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (state_q == S_NOBUF),
        .rx_valid  (rx_valid),
        .rx_last   (rx_last),
        .poll      (poll_demand),
        .release_o (drop_release)
    );

    assign byte_addr = buf_q + ADDR_W'(cnt_q);

    // Drive the memory request for the current state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_q;
        mem_wdata = '0;
        mem_wstrb = 4'h0;
        case (state_q)
            S_FSTAT: mem_req = 1'b1;
            S_FSIZE: begin mem_req = 1'b1; mem_addr = desc_q + OFS_SIZE; end
            S_FADDR: begin mem_req = 1'b1; mem_addr = desc_q + OFS_BUF;  end
            S_FNEXT: begin mem_req = 1'b1; mem_addr = desc_q + OFS_LINK; end
            S_WBYTE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = byte_addr;
                mem_wdata = {4{byte_q}};
                mem_wstrb = 4'b0001 << byte_addr[1:0];
            end
            S_WSTAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = stat_word;
                mem_wstrb = 4'hF;
            end
            default: ;
        endcase
    end

    assign rx_ready = (state_q == S_RXIDLE) || (state_q == S_NOBUF);
    assign rx_ok    = ok_q;
    assign nobuf    = nobuf_q;

    // Main sequencer: fetch, receive, write back, advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_FSTAT;
            desc_q  <= ring_base;
            next_q  <= '0;
            buf_q   <= '0;
            cap_q   <= '0;
            cnt_q   <= '0;
            byte_q  <= '0;
            last_q  <= 1'b0;
            trunc_q <= 1'b0;
            err_q   <= '0;
            ok_q    <= 1'b0;
            nobuf_q <= 1'b0;
        end else begin
            ok_q <= 1'b0;
            case (state_q)
                S_FSTAT: if (mem_ack) begin
                    cnt_q   <= '0;
                    trunc_q <= 1'b0;
                    err_q   <= '0;
                    last_q  <= 1'b0;
                    if (mem_rdata[OWN_BIT]) begin
                        state_q <= S_FSIZE;
                    end else begin
                        state_q <= S_NOBUF;
                        nobuf_q <= 1'b1;
                    end
                end
                S_FSIZE: if (mem_ack) begin
                    cap_q   <= mem_rdata[LEN_W-1:0];
                    state_q <= S_FADDR;
                end
                S_FADDR: if (mem_ack) begin
                    buf_q   <= mem_rdata[ADDR_W-1:0];
                    state_q <= S_FNEXT;
                end
                S_FNEXT: if (mem_ack) begin
                    next_q  <= mem_rdata[ADDR_W-1:0];
                    state_q <= S_RXIDLE;
                end
                S_NOBUF: if (drop_release) begin
                    nobuf_q <= 1'b0;
                    state_q <= S_FSTAT;
                end
                S_RXIDLE: if (rx_valid) begin
                    if (rx_last)
                        err_q <= rx_err;
                    if (cnt_q < cap_q) begin
                        byte_q  <= rx_data;
                        last_q  <= rx_last;
                        state_q <= S_WBYTE;
                    end else begin
                        trunc_q <= 1'b1;
                        if (rx_last)
                            state_q <= S_WSTAT;
                    end
                end
                S_WBYTE: if (mem_ack) begin
                    cnt_q   <= cnt_q + 1'b1;
                    state_q <= last_q ? S_WSTAT : S_RXIDLE;
                end
                S_WSTAT: if (mem_ack) begin
                    ok_q    <= 1'b1;
                    desc_q  <= next_q;
                    state_q <= S_FSTAT;
                end
                default: state_q <= S_FSTAT;
            endcase
        end
    end
endmodule

// File: rtl/rxr_ring_writer_chk.sv
// Checker for the receive ring writer, attached by bind. It watches only
// the block's ports.
module rxr_ring_writer_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic [3:0]        mem_wstrb,
    input logic              mem_ack,
    input logic              rx_ok,
    input logic              nobuf
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R1
    AST_ONE_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_wstrb != 4'hF |-> $countones(mem_wstrb) == 1); // R1
    AST_OWN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_wstrb == 4'hF |-> !mem_wdata[31] && mem_wdata[9] && mem_wdata[8]); // R2
    AST_OK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok |=> !rx_ok); // R7
    AST_NOBUF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        nobuf |-> !(mem_req && mem_we)); // R8
endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_wstrb (mem_wstrb),
    .mem_ack   (mem_ack),
    .rx_ok     (rx_ok),
    .nobuf     (nobuf)
);

// File: tb/sim_rxr_ring_writer.sv
module sim_rxr_ring_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ring_base = 32'h100;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic [7:0]  rx_err = '0;
    logic        rx_ready;
    logic        poll_demand = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_wstrb;
    logic        rx_ok, nobuf;

    int total = 0;
    int bad = 0;
    int ok_count = 0;
    logic [31:0] mem [0:1023];

    always #4 clk = ~clk;

    rxr_ring_writer u0 (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_err(rx_err), .rx_ready(rx_ready), .poll_demand(poll_demand),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .rx_ok(rx_ok), .nobuf(nobuf)
    );

    // Memory model: acknowledges one cycle after a request
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[11:2]];
            if (mem_we)
                for (int b = 0; b < 4; b++)
                    if (mem_wstrb[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(posedge clk) if (rst_n && rx_ok) ok_count <= ok_count + 1;

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [7:0] rd8(input int a);
        return mem[a >> 2][8*(a & 3) +: 8];
    endfunction

    function automatic logic [31:0] exp_stat(input int len, input logic [7:0] err);
        return (32'(len) << 16) | 32'h300 | {24'h0, err};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic last, input logic [7:0] err);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_last = last; rx_err = err;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic send_frame(input int n, input logic [7:0] base, input logic [7:0] err);
        for (int i = 0; i < n; i++) send_byte(base + 8'(i), i == n - 1, err);
    endtask

    task automatic pulse_poll();
        @(negedge clk); poll_demand = 1'b1;
        @(negedge clk); poll_demand = 1'b0;
    endtask

    task automatic set_desc(input int a, input int cap, input int bufa, input int link);
        mem[a >> 2]       = 32'h8000_0000;
        mem[(a >> 2) + 1] = 32'(cap);
        mem[(a >> 2) + 2] = 32'(bufa);
        mem[(a >> 2) + 3] = 32'(link);
    endtask

    // R11: quiet outputs during reset
    task automatic t_reset();
        wait_cyc(3);
        check("R11 rx_ready", {31'b0, rx_ready}, 32'h0);
        check("R11 rx_ok", {31'b0, rx_ok}, 32'h0);
        check("R11 nobuf", {31'b0, nobuf}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    // R1 R2 R3 R7: plain frame into first descriptor
    task automatic t_plain();
        logic ok_bytes = 1'b1;
        send_frame(8, 8'h10, 8'h00);
        wait_cyc(20);
        for (int i = 0; i < 8; i++) if (rd8(32'h400 + i) !== 8'(8'h10 + i)) ok_bytes = 1'b0;
        check("R1 bytes in order", {31'b0, ok_bytes}, 32'h1);
        check("R2 own bit cleared", {31'b0, mem[32'h100 >> 2][31]}, 32'h0);
        check("R2 chain bits", {29'b0, mem[32'h100 >> 2][10:8]}, 32'h3);
        check("R3 length field", {21'b0, mem[32'h100 >> 2][26:16]}, 32'd8);
        check("R7 ok pulses", 32'(ok_count), 32'd1);
    endtask

    // R5: over-long frame into 6-byte buffer
    task automatic t_trunc();
        send_frame(10, 8'h30, 8'h00);
        wait_cyc(20);
        check("R5 status", mem[32'h110 >> 2], exp_stat(6, 8'h10));
        check("R5 last kept byte", {24'b0, rd8(32'h605)}, 32'h35);
        check("R5 byte past capacity", {24'b0, rd8(32'h606)}, 32'h00);
    endtask

    // R4: error sideband mapping
    task automatic t_errors();
        send_frame(5, 8'h40, 8'h26);
        wait_cyc(20);
        check("R4 error bits", mem[32'h120 >> 2], exp_stat(5, 8'h26));
        check("R7 ok pulses", 32'(ok_count), 32'd3);
    endtask

    // R6 R8: wrap onto a descriptor the host still holds
    task automatic t_exhaust();
        check("R8 nobuf after wrap", {31'b0, nobuf}, 32'h1);
        check("R8 ready while dropping", {31'b0, rx_ready}, 32'h1);
        send_frame(4, 8'h60, 8'h00);
        wait_cyc(10);
        check("R8 dropped frame not written", {24'b0, rd8(32'h400)}, 32'h10);
        check("R7 no pulse on drop", 32'(ok_count), 32'd3);
    endtask

    // R9 R10: poll inside a dropped frame, then resume at the boundary
    task automatic t_poll_mid();
        mem[32'h100 >> 2] = 32'h8000_0000;
        send_byte(8'h50, 1'b0, 8'h00);
        send_byte(8'h51, 1'b0, 8'h00);
        pulse_poll();
        check("R10 still dropping mid frame", {31'b0, nobuf}, 32'h1);
        send_byte(8'h52, 1'b0, 8'h00);
        send_byte(8'h53, 1'b1, 8'h00);
        wait_cyc(10);
        check("R9 nobuf cleared", {31'b0, nobuf}, 32'h0);
        check("R10 tail not written", {24'b0, rd8(32'h400)}, 32'h10);
        check("R10 descriptor still owned", {31'b0, mem[32'h100 >> 2][31]}, 32'h1);
        send_frame(3, 8'h70, 8'h00);
        wait_cyc(20);
        check("R9 R6 reused descriptor", mem[32'h100 >> 2], exp_stat(3, 8'h00));
        check("R9 new bytes", {8'b0, rd8(32'h402), rd8(32'h401), rd8(32'h400)}, 32'h0072_7170);
        check("R7 ok pulses", 32'(ok_count), 32'd4);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        set_desc(32'h100, 64, 32'h400, 32'h110);
        set_desc(32'h110, 6,  32'h600, 32'h120);
        set_desc(32'h120, 64, 32'h800, 32'h100);
        t_reset();
        t_plain();
        t_trunc();
        t_errors();
        t_exhaust();
        t_poll_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule